// File: doc/BRIEF.md
# Standby Power-State Sequencer

This block steps a small processor system between four power states. In run, the CPU clock is on. In halt, the CPU clock is gated but every oscillator keeps running. In stop, both high-speed oscillators are off. In snooze, a stopped system briefly powers the high-speed on-chip oscillator and the peripheral clock. This lets a serial receiver or a timer-triggered converter work without waking the CPU. Software-side requests (`halt_req`, `stop_req`) start entry. A pending interrupt (`irq_pend`) starts exit.

When stop is left while the external crystal is the selected source, the crystal needs time to settle. The block holds the CPU clock off and counts a programmable number of reference ticks first. During this wait, `mode` still reads stop and `wait_busy` is high. Stop is refused while the CPU runs from the subsystem clock. A configuration input decides whether the low-speed on-chip oscillator keeps running while the system is not in run.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the block is in run: `mode`=0, `cpu_clk_en`=1, `hs_xtal_en`=1, `hs_ocosc_en`=1, `per_clk_en`=1, `ls_osc_en`=1, `wait_busy`=0.
- R2: In halt (`mode`=1), `cpu_clk_en`=0 while both high-speed enables and `per_clk_en` stay 1. The block stays in halt until `irq_pend`, then it returns to run on the next edge with no wait.
- R3: In stop (`mode`=2, `wait_busy`=0), `cpu_clk_en`, `hs_xtal_en`, `hs_ocosc_en` and `per_clk_en` are all 0.
- R4: `clk_src` encoding is 0 = high-speed on-chip, 1 = external crystal, 2 or 3 = subsystem (bit 1 set). With bit 1 set, `stop_req` alone leaves the block in run, while `halt_req` still enters halt.
- R5: When `halt_req` and `stop_req` are both high in run, the block enters stop if stop is allowed and halt otherwise.
- R6: In stop, `snz_ser_req` or `snz_conv_req` moves the block to snooze (`mode`=3) only when `clk_src`=0; otherwise the block stays in stop. In snooze, `per_clk_en`=1, `hs_ocosc_en`=1, `hs_xtal_en`=0 and `cpu_clk_en`=0.
- R7: In snooze, `snz_done` without `irq_pend` returns the block to stop. `irq_pend` takes it to run with no wait, and it wins over a simultaneous `snz_done`.
- R8: Consider an interrupt in stop with `clk_src`=1 and `wait_cycles`=N>0. The block holds `mode`=2 with `wait_busy`=1, `cpu_clk_en`=0 and both high-speed enables 1. It counts N `ref_tick` cycles. With `ref_tick` held high, `cpu_clk_en` returns on the (N+2)th clock edge after the interrupt is presented.
- R9: While `ref_tick` is low, the stabilization count does not advance, and the block stays in the wait.
- R10: An interrupt in stop goes straight to run on the next edge when `wait_cycles`=0 or `clk_src`≠1.
- R11: Outside run and the stabilization wait, `ls_osc_en` follows `ls_keep`; in run and the wait it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Request to enter halt |
| stop_req | input | 1 | Request to enter stop |
| clk_src | input | 2 | Selected CPU/peripheral clock source |
| irq_pend | input | 1 | Interrupt pending, releases halt/stop/snooze |
| snz_ser_req | input | 1 | Serial receive start trigger |
| snz_conv_req | input | 1 | Timer-triggered conversion trigger |
| snz_done | input | 1 | Snooze work finished without interrupt |
| ls_keep | input | 1 | Keep low-speed oscillator running in low-power states |
| ref_tick | input | 1 | Reference tick for stabilization counting |
| wait_cycles | input | WAIT_W | Stabilization tick count, 0 = none |
| cpu_clk_en | output | 1 | CPU clock enable |
| hs_xtal_en | output | 1 | External crystal oscillator enable |
| hs_ocosc_en | output | 1 | High-speed on-chip oscillator enable |
| ls_osc_en | output | 1 | Low-speed on-chip oscillator enable |
| per_clk_en | output | 1 | Snooze-capable peripheral clock enable |
| mode | output | 2 | 0 run, 1 halt, 2 stop, 3 snooze |
| wait_busy | output | 1 | Stabilization wait in progress |

## Verification
The hardest condition to reach is the stabilization wait. It needs stop to be entered under an allowed source, then an interrupt under the crystal source with a nonzero count. The wait must then be observed while the reference tick is withheld. The directed tests build this chain: enter stop, raise the interrupt with `clk_src`=1, and count edges until the CPU clock returns. A second pass holds `ref_tick` low for many cycles before releasing it. Snooze round trips, and a simultaneous `snz_done` with an interrupt, are reached through the vector table.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_STOP   = 3'd2,
        ST_SNOOZE = 3'd3,
        ST_WAKE   = 3'd4
    } st_e;

    localparam logic [1:0] MODE_RUN    = 2'd0;
    localparam logic [1:0] MODE_HALT   = 2'd1;
    localparam logic [1:0] MODE_STOP   = 2'd2;
    localparam logic [1:0] MODE_SNOOZE = 2'd3;

    localparam logic [1:0] SRC_OCOSC = 2'd0;
    localparam logic [1:0] SRC_XTAL  = 2'd1;

    typedef struct packed {
        st_e st;
    } seq_s;
endpackage

// File: rtl/stby_wait.sv
module stby_wait #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              active,
    input  logic              tick,
    output logic              zero
);
    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (active && tick && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q.cnt == '0);
endmodule

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic [1:0] clk_src,
    input  logic       irq_pend,
    input  logic       snz_trig,
    input  logic       snz_done,
    input  logic       wait_nz,
    input  logic       cnt_zero,
    output logic       load_wait,
    output st_e        st
);
    seq_s seq_d, seq_q;

    logic src_sub, src_xtal, src_ocosc;
    assign src_sub   = clk_src[1];
    assign src_xtal  = (clk_src == SRC_XTAL);
    assign src_ocosc = (clk_src == SRC_OCOSC);

    always_comb begin
        seq_d     = seq_q;
        load_wait = 1'b0;
        unique case (seq_q.st)
            ST_RUN: begin
                if (stop_req && !src_sub) seq_d.st = ST_STOP;
                else if (halt_req)        seq_d.st = ST_HALT;
            end
            ST_HALT: begin
                if (irq_pend) seq_d.st = ST_RUN;
            end
            ST_STOP: begin
                if (irq_pend) begin
                    if (src_xtal && wait_nz) begin
                        seq_d.st  = ST_WAKE;
                        load_wait = 1'b1;
                    end else begin
                        seq_d.st = ST_RUN;
                    end
                end else if (snz_trig && src_ocosc) begin
                    seq_d.st = ST_SNOOZE;
                end
            end
            ST_SNOOZE: begin
                if (irq_pend)      seq_d.st = ST_RUN;
                else if (snz_done) seq_d.st = ST_STOP;
            end
            ST_WAKE: begin
                if (cnt_zero) seq_d.st = ST_RUN;
            end
            default: seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_RUN};
        else        seq_q <= seq_d;
    end

    assign st = seq_q.st;
endmodule

// File: rtl/stby_gate.sv
module stby_gate
    import stby_pkg::*;
(
    input  st_e        st,
    input  logic       ls_keep,
    output logic       cpu_clk_en,
    output logic       hs_xtal_en,
    output logic       hs_ocosc_en,
    output logic       ls_osc_en,
    output logic       per_clk_en,
    output logic [1:0] mode,
    output logic       wait_busy
);
    always_comb begin
        cpu_clk_en  = 1'b0;
        hs_xtal_en  = 1'b0;
        hs_ocosc_en = 1'b0;
        ls_osc_en   = ls_keep;
        per_clk_en  = 1'b0;
        mode        = MODE_RUN;
        wait_busy   = 1'b0;
        unique case (st)
            ST_RUN: begin
                cpu_clk_en  = 1'b1;
                hs_xtal_en  = 1'b1;
                hs_ocosc_en = 1'b1;
                ls_osc_en   = 1'b1;
                per_clk_en  = 1'b1;
            end
            ST_HALT: begin
                hs_xtal_en  = 1'b1;
                hs_ocosc_en = 1'b1;
                per_clk_en  = 1'b1;
                mode        = MODE_HALT;
            end
            ST_STOP: begin
                mode = MODE_STOP;
            end
            ST_SNOOZE: begin
                hs_ocosc_en = 1'b1;
                per_clk_en  = 1'b1;
                mode        = MODE_SNOOZE;
            end
            ST_WAKE: begin
                hs_xtal_en  = 1'b1;
                hs_ocosc_en = 1'b1;
                ls_osc_en   = 1'b1;
                mode        = MODE_STOP;
                wait_busy   = 1'b1;
            end
            default: begin
                mode = MODE_RUN;
            end
        endcase
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              stop_req,
    input  logic [1:0]        clk_src,
    input  logic              irq_pend,
    input  logic              snz_ser_req,
    input  logic              snz_conv_req,
    input  logic              snz_done,
    input  logic              ls_keep,
    input  logic              ref_tick,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              cpu_clk_en,
    output logic              hs_xtal_en,
    output logic              hs_ocosc_en,
    output logic              ls_osc_en,
    output logic              per_clk_en,
    output logic [1:0]        mode,
    output logic              wait_busy
);
    st_e  st;
    logic load_wait;
    logic cnt_zero;
    logic wait_nz;
    logic snz_trig;

    assign wait_nz  = |wait_cycles;
    assign snz_trig = snz_ser_req | snz_conv_req;

    stby_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .stop_req  (stop_req),
        .clk_src   (clk_src),
        .irq_pend  (irq_pend),
        .snz_trig  (snz_trig),
        .snz_done  (snz_done),
        .wait_nz   (wait_nz),
        .cnt_zero  (cnt_zero),
        .load_wait (load_wait),
        .st        (st)
    );

    stby_wait #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_wait),
        .load_val (wait_cycles),
        .active   (st == ST_WAKE),
        .tick     (ref_tick),
        .zero     (cnt_zero)
    );

    stby_gate u_gate (
        .st          (st),
        .ls_keep     (ls_keep),
        .cpu_clk_en  (cpu_clk_en),
        .hs_xtal_en  (hs_xtal_en),
        .hs_ocosc_en (hs_ocosc_en),
        .ls_osc_en   (ls_osc_en),
        .per_clk_en  (per_clk_en),
        .mode        (mode),
        .wait_busy   (wait_busy)
    );
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic [1:0] clk_src,
    input logic       irq_pend,
    input logic       ls_keep,
    input logic       cpu_clk_en,
    input logic       hs_xtal_en,
    input logic       hs_ocosc_en,
    input logic       ls_osc_en,
    input logic       per_clk_en,
    input logic [1:0] mode,
    input logic       wait_busy
);
    // R2
    halt_gates_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (!cpu_clk_en && hs_xtal_en && hs_ocosc_en && per_clk_en));

    // R2
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && irq_pend) |=> (mode == 2'd0 && cpu_clk_en));

    // R3
    stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !wait_busy) |-> (!cpu_clk_en && !hs_xtal_en && !hs_ocosc_en && !per_clk_en));

    // R4
    stop_refused_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && stop_req && clk_src[1]) |=> (mode != 2'd2));

    // R6
    snooze_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (per_clk_en && hs_ocosc_en && !hs_xtal_en && !cpu_clk_en));

    // R6
    snooze_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd2) |-> ($past(clk_src) == 2'd0));

    // R8
    wake_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_busy |-> (!cpu_clk_en && hs_xtal_en && hs_ocosc_en && mode == 2'd2));

    // R11
    ls_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !wait_busy) |-> (ls_osc_en == ls_keep));

    // R1
    cpu_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (mode == 2'd0));
endmodule

bind stby_ctrl stby_ctrl_chk u_chk (.*);

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;
    localparam int WAIT_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              halt_req = 1'b0, stop_req = 1'b0;
    logic [1:0]        clk_src = 2'd0;
    logic              irq_pend = 1'b0, snz_ser_req = 1'b0, snz_conv_req = 1'b0;
    logic              snz_done = 1'b0, ls_keep = 1'b0, ref_tick = 1'b1;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic              cpu_clk_en, hs_xtal_en, hs_ocosc_en, ls_osc_en, per_clk_en;
    logic [1:0]        mode;
    logic              wait_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stby_ctrl #(.WAIT_W(WAIT_W)) u_dut (.*);

    // vector: {halt,stop,src[1:0],irq,ser,conv,done,ls_keep} , expect {mode[1:0],cpu,xtal,ocosc,ls,per}
    localparam int NV = 23;
    localparam logic [15:0] VEC [NV] = '{
        {9'b0_0_00_0_0_0_0_0, 7'b00_11111},  // R1 idle run
        {9'b1_0_00_0_0_0_0_0, 7'b01_01101},  // R2 enter halt
        {9'b0_0_00_0_0_0_0_1, 7'b01_01111},  // R2 hold, R11 ls on
        {9'b0_0_00_1_0_0_0_0, 7'b00_11111},  // R2 release
        {9'b0_1_10_0_0_0_0_0, 7'b00_11111},  // R4 stop refused
        {9'b1_0_10_0_0_0_0_0, 7'b01_01101},  // R4 halt on subsystem
        {9'b0_0_10_1_0_0_0_0, 7'b00_11111},  // R2 release
        {9'b1_1_00_0_0_0_0_0, 7'b10_00000},  // R5 stop wins
        {9'b0_0_01_0_1_0_0_0, 7'b10_00000},  // R6 trigger ignored on crystal
        {9'b0_0_00_0_0_1_0_1, 7'b11_00111},  // R6 conv trigger enters snooze
        {9'b0_0_00_0_0_0_0_1, 7'b11_00111},  // R6 stays in snooze
        {9'b0_0_00_0_0_0_1_0, 7'b10_00000},  // R7 done back to stop
        {9'b0_0_00_0_1_0_0_0, 7'b11_00101},  // R6 serial trigger
        {9'b0_0_00_1_0_0_0_0, 7'b00_11111},  // R7 irq to run
        {9'b1_1_11_0_0_0_0_0, 7'b01_01101},  // R5 halt when stop refused
        {9'b0_0_11_1_0_0_0_0, 7'b00_11111},  // R2 release
        {9'b0_1_00_0_0_0_0_1, 7'b10_00010},  // R3 stop, R11 ls kept
        {9'b0_0_01_1_0_0_0_0, 7'b00_11111},  // R10 crystal, zero wait
        {9'b0_1_00_0_0_0_0_0, 7'b10_00000},  // R3 stop
        {9'b0_0_00_1_0_0_0_0, 7'b00_11111},  // R10 on-chip source
        {9'b0_1_00_0_0_0_0_0, 7'b10_00000},  // R3 stop
        {9'b0_0_00_0_0_1_0_0, 7'b11_00101},  // R6 snooze
        {9'b0_0_00_1_0_0_1_0, 7'b00_11111}   // R7 irq beats done
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {halt_req, stop_req, clk_src, irq_pend, snz_ser_req, snz_conv_req, snz_done, ls_keep} = v;
    endtask

    function automatic logic [6:0] outs();
        return {mode, cpu_clk_en, hs_xtal_en, hs_ocosc_en, ls_osc_en, per_clk_en};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {25'd0, outs()}, {25'd0, 7'b00_11111});
        check("R1", {31'd0, wait_busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15:7]);
            @(negedge clk);
            check($sformatf("vector %0d", i), {25'd0, outs()}, {25'd0, VEC[i][6:0]});
        end
        drive(9'd0);
        @(negedge clk);

        // R8 stabilization wait, N=5, tick high
        begin
            int edges;
            wait_cycles = 16'd5;
            ref_tick    = 1'b1;
            drive(9'b0_1_01_0_0_0_0_0);
            @(negedge clk);
            check("R3", {30'd0, mode}, 32'd2);
            drive(9'b0_0_01_1_0_0_0_0);
            @(negedge clk);
            drive(9'b0_0_01_0_0_0_0_0);
            edges = 1;
            check("R8", {25'd0, outs()}, {25'd0, 7'b10_01110});
            check("R8", {31'd0, wait_busy}, 32'd1);
            while (!cpu_clk_en && edges < 50) begin
                @(negedge clk);
                edges++;
            end
            check("R8", edges, 32'd7);
            check("R8", {31'd0, wait_busy}, 32'd0);
        end

        // R9 tick low freezes the count
        wait_cycles = 16'd3;
        ref_tick    = 1'b0;
        drive(9'b0_1_01_0_0_0_0_0);
        @(negedge clk);
        drive(9'b0_0_01_1_0_0_0_0);
        @(negedge clk);
        drive(9'b0_0_01_0_0_0_0_0);
        repeat (20) @(negedge clk);
        check("R9", {30'd0, wait_busy, cpu_clk_en}, 32'd2);
        ref_tick = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", {31'd0, cpu_clk_en}, 32'd1);

        // R10 crystal source but interrupt in stop with zero wait handled in table; nonzero wait on on-chip source
        wait_cycles = 16'd9;
        drive(9'b0_1_00_0_0_0_0_0);
        @(negedge clk);
        drive(9'b0_0_00_1_0_0_0_0);
        @(negedge clk);
        check("R10", {30'd0, wait_busy, cpu_clk_en}, 32'd1);

        // R1 reset in the middle of a wait
        drive(9'b0_1_01_0_0_0_0_0);
        @(negedge clk);
        drive(9'b0_0_01_1_0_0_0_0);
        @(negedge clk);
        drive(9'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {24'd0, wait_busy, outs()}, {24'd0, 8'b0_00_11111});
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule